// File: doc/BRIEF.md
# Sample and Toggle Boundary Cell Array

This block holds the boundary cells for both 8-bit sides of a bidirectional transceiver while a boundary test mode is running. In this mode the cells sample the pins and toggle the outputs. Each pin has one cell. A cell has a capture/shift stage, clocked on the rising test clock, and a shadow stage, clocked on the falling test clock.

Two direction enables decide which side receives and which side drives. On the receiving side, each cell captures its pin on every rising test clock. The shadow stage passes that value to the core logic on the following falling edge. On the driving side, each cell inverts its stage on every rising test clock. The shadow stage sends the new value to the pins on the following falling edge, so the output pattern alternates every test clock. The output-enable cell value for the driving side decides whether its pins drive or float.

If the mode is off, or if the direction enables do not select exactly one direction, the cells keep their contents and no pin is driven. Serial shifting and the test access port state machine are handled elsewhere.

Top module: `samp_toggle_cells`

## Requirements
- R1: After reset, all capture and shadow stages are 0. `core_a`, `core_b`, `pin_a_out` and `pin_b_out` read 0x00. With `mode_act` low, both drive-enable buses read 0x00.
- R2: While the array is active, every rising `tck` loads each cell on the receiving side with its current pin value.
- R3: A value captured on a rising edge appears on the receiving side's core output (`core_a` or `core_b`) at the next falling edge. Until then, that core output keeps its previous value.
- R4: While active, each cell on the driving side inverts its stage on every rising `tck`. The pin output changes only at the following falling edge, so it alternates between complementary values on successive falling edges. Starting from reset, the first value driven is 0xFF.
- R5: For the driving side, every bit of the drive-enable bus equals that side's output-enable cell value (1 = drive, 0 = high impedance). The receiving side's drive-enable bus is 0x00. These enables follow their inputs combinationally.
- R6: `en_ab`=1 with `en_ba`=0 makes side A the receiving side and side B the driving side. `en_ba`=1 with `en_ab`=0 swaps the roles.
- R7: When `en_ab` equals `en_ba`, the array is bypassed. No cell captures or toggles, every output keeps its value, and both drive-enable buses are 0x00.
- R8: When `mode_act` is low, no cell captures or toggles, all outputs hold, and both drive-enable buses are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_act | input | 1 | Sample/toggle mode is selected |
| en_ab | input | 1 | Enable for data flow from A to B |
| en_ba | input | 1 | Enable for data flow from B to A |
| oec_a | input | 1 | Output-enable cell value for side A |
| oec_b | input | 1 | Output-enable cell value for side B |
| pin_a_in | input | 8 | Values present on the side A pins |
| pin_b_in | input | 8 | Values present on the side B pins |
| core_a | output | 8 | Side A shadow stages, sent to core logic |
| core_b | output | 8 | Side B shadow stages, sent to core logic |
| pin_a_out | output | 8 | Drive values for the side A pins |
| pin_b_out | output | 8 | Drive values for the side B pins |
| drv_en_a | output | 8 | Per-pin drive enables for side A |
| drv_en_b | output | 8 | Per-pin drive enables for side B |

## Verification
Captures and toggles happen on a rising edge, but they become visible only half a clock later, at the next falling edge. The drive enables are combinational and follow their inputs within the same cycle. The bench changes inputs just after a rising edge. It checks core and pin outputs just after that rising edge, where they must still show their old values, and again just after the following falling edge, where they must show the new ones. Drive enables are checked one time unit after the inputs change.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    ROLE_IDLE = 2'd0,
    ROLE_A_IN = 2'd1,
    ROLE_B_IN = 2'd2
  } role_e;
endpackage

// File: rtl/stc_rst_sync.sv
module stc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/stc_mode_decode.sv
module stc_mode_decode
  import stc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         mode_act,
  input  logic         en_ab,
  input  logic         en_ba,
  input  logic         oec_a,
  input  logic         oec_b,
  output logic         cap_a,
  output logic         tog_a,
  output logic         cap_b,
  output logic         tog_b,
  output logic [W-1:0] drv_a,
  output logic [W-1:0] drv_b
);
  role_e role;

  always_comb begin
    role = ROLE_IDLE;
    if (mode_act && (en_ab != en_ba)) begin
      role = en_ab ? ROLE_A_IN : ROLE_B_IN;
    end
  end

  always_comb begin
    cap_a = (role == ROLE_A_IN);
    tog_b = (role == ROLE_A_IN);
    cap_b = (role == ROLE_B_IN);
    tog_a = (role == ROLE_B_IN);
    drv_a = {W{tog_a & oec_a}};
    drv_b = {W{tog_b & oec_b}};
  end
endmodule

// File: rtl/stc_cell.sv
module stc_cell (
  input  logic tck,
  input  logic rst_n,
  input  logic cap,
  input  logic tog,
  input  logic pin,
  output logic stage_q,
  output logic shadow_q
);
  logic stage_d;
  logic shadow_d;
  logic upd;

  assign upd = cap | tog;

  always_comb begin
    stage_d = stage_q;
    if (cap)      stage_d = pin;
    else if (tog) stage_d = ~stage_q;
  end

  always_comb begin
    shadow_d = upd ? stage_q : shadow_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) stage_q <= 1'b0;
    else        stage_q <= stage_d;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) shadow_q <= 1'b0;
    else        shadow_q <= shadow_d;
  end
endmodule

// File: rtl/stc_cell_bank.sv
module stc_cell_bank #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         tog,
  input  logic [W-1:0] pins,
  output logic [W-1:0] stage,
  output logic [W-1:0] shadow
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    stc_cell u_cell (
      .tck      (tck),
      .rst_n    (rst_n),
      .cap      (cap),
      .tog      (tog),
      .pin      (pins[i]),
      .stage_q  (stage[i]),
      .shadow_q (shadow[i])
    );
  end
endmodule

// File: rtl/samp_toggle_cells.sv
module samp_toggle_cells #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         mode_act,
  input  logic         en_ab,
  input  logic         en_ba,
  input  logic         oec_a,
  input  logic         oec_b,
  input  logic [W-1:0] pin_a_in,
  input  logic [W-1:0] pin_b_in,
  output logic [W-1:0] core_a,
  output logic [W-1:0] core_b,
  output logic [W-1:0] pin_a_out,
  output logic [W-1:0] pin_b_out,
  output logic [W-1:0] drv_en_a,
  output logic [W-1:0] drv_en_b
);
  logic         rst_q;
  logic         cap_a, tog_a, cap_b, tog_b;
  logic [W-1:0] stage_a, stage_b;
  logic [W-1:0] shadow_a, shadow_b;

  stc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (tck),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  stc_mode_decode #(.W(W)) u_dec (
    .mode_act (mode_act),
    .en_ab    (en_ab),
    .en_ba    (en_ba),
    .oec_a    (oec_a),
    .oec_b    (oec_b),
    .cap_a    (cap_a),
    .tog_a    (tog_a),
    .cap_b    (cap_b),
    .tog_b    (tog_b),
    .drv_a    (drv_en_a),
    .drv_b    (drv_en_b)
  );

  stc_cell_bank #(.W(W)) u_bank_a (
    .tck    (tck),
    .rst_n  (rst_q),
    .cap    (cap_a),
    .tog    (tog_a),
    .pins   (pin_a_in),
    .stage  (stage_a),
    .shadow (shadow_a)
  );

  stc_cell_bank #(.W(W)) u_bank_b (
    .tck    (tck),
    .rst_n  (rst_q),
    .cap    (cap_b),
    .tog    (tog_b),
    .pins   (pin_b_in),
    .stage  (stage_b),
    .shadow (shadow_b)
  );

  assign core_a    = shadow_a;
  assign core_b    = shadow_b;
  assign pin_a_out = shadow_a;
  assign pin_b_out = shadow_b;
endmodule

// File: rtl/samp_toggle_cells_chk.sv
module samp_toggle_cells_chk #(
  parameter int W = 8
) (
  input logic         tck,
  input logic         rst_q,
  input logic         mode_act,
  input logic         en_ab,
  input logic         en_ba,
  input logic         oec_b,
  input logic         cap_a,
  input logic         tog_b,
  input logic [W-1:0] pin_a_in,
  input logic [W-1:0] stage_a,
  input logic [W-1:0] stage_b,
  input logic [W-1:0] shadow_a,
  input logic [W-1:0] drv_en_a,
  input logic [W-1:0] drv_en_b
);
  a_r2_capture: assert property (@(posedge tck) disable iff (!rst_q)
    ($past(cap_a) && $past(rst_q)) |-> stage_a == $past(pin_a_in));

  a_r4_toggle: assert property (@(posedge tck) disable iff (!rst_q)
    ($past(tog_b) && $past(rst_q)) |-> stage_b == ~$past(stage_b));

  a_r3_shadow_follow: assert property (@(negedge tck) disable iff (!rst_q)
    ($past(cap_a) && $past(rst_q)) |-> shadow_a == $past(stage_a));

  a_r5_drive_b: assert property (@(posedge tck) disable iff (!rst_q)
    (mode_act && en_ab && !en_ba) |-> (drv_en_b == {W{oec_b}} && drv_en_a == '0));

  a_r6_one_side: assert property (@(posedge tck) disable iff (!rst_q)
    !((|drv_en_a) && (|drv_en_b)));

  a_r7_bypass_hold: assert property (@(posedge tck) disable iff (!rst_q)
    (en_ab == en_ba) |=> ($stable(stage_a) && $stable(stage_b)));

  a_r8_idle_float: assert property (@(posedge tck) disable iff (!rst_q)
    !mode_act |-> (drv_en_a == '0 && drv_en_b == '0));
endmodule

bind samp_toggle_cells samp_toggle_cells_chk #(.W(W)) u_chk (
  .tck      (tck),
  .rst_q    (rst_q),
  .mode_act (mode_act),
  .en_ab    (en_ab),
  .en_ba    (en_ba),
  .oec_b    (oec_b),
  .cap_a    (cap_a),
  .tog_b    (tog_b),
  .pin_a_in (pin_a_in),
  .stage_a  (stage_a),
  .stage_b  (stage_b),
  .shadow_a (shadow_a),
  .drv_en_a (drv_en_a),
  .drv_en_b (drv_en_b)
);

// File: tb/sim_samp_toggle_cells.sv
module sim_samp_toggle_cells;
  localparam int PERIOD = 10;
  localparam int W      = 8;

  logic         tck = 1'b0;
  logic         rst_n;
  logic         mode_act, en_ab, en_ba, oec_a, oec_b;
  logic [W-1:0] pin_a_in, pin_b_in;
  logic [W-1:0] core_a, core_b, pin_a_out, pin_b_out, drv_en_a, drv_en_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W-1:0] b_exp;
  logic [W-1:0] a_hold;

  always #(PERIOD/2) tck = ~tck;

  samp_toggle_cells #(.W(W)) u0 (
    .tck(tck), .rst_n(rst_n), .mode_act(mode_act), .en_ab(en_ab), .en_ba(en_ba),
    .oec_a(oec_a), .oec_b(oec_b), .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
    .core_a(core_a), .core_b(core_b), .pin_a_out(pin_a_out), .pin_b_out(pin_b_out),
    .drv_en_a(drv_en_a), .drv_en_b(drv_en_b)
  );

  task automatic check8(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic after_rise();
    @(posedge tck); #1;
  endtask

  task automatic after_fall();
    @(negedge tck); #1;
  endtask

  function automatic logic [W-1:0] va(input int i);
    return 8'h3C + 8'(i * 37);
  endfunction

  task automatic t_reset();
    check8("R1 core_a", core_a, 8'h00);
    check8("R1 core_b", core_b, 8'h00);
    check8("R1 pin_a_out", pin_a_out, 8'h00);
    check8("R1 pin_b_out", pin_b_out, 8'h00);
    check8("R1 drv_en_a", drv_en_a, 8'h00);
    check8("R1 drv_en_b", drv_en_b, 8'h00);
  endtask

  task automatic t_a_to_b();
    logic [W-1:0] prev_core;
    after_rise();
    mode_act = 1'b1; en_ab = 1'b1; en_ba = 1'b0; oec_a = 1'b1; oec_b = 1'b1;
    pin_a_in = va(0);
    #1;
    check8("R5 drv_en_b on", drv_en_b, 8'hFF);
    check8("R6 drv_en_a receiving", drv_en_a, 8'h00);
    b_exp = 8'h00;
    prev_core = 8'h00;
    for (int i = 0; i < 4; i++) begin
      after_rise();
      check8("R3 core_a before fall", core_a, prev_core);
      check8("R4 pin_b_out before fall", pin_b_out, b_exp);
      pin_a_in = va(i + 1);
      after_fall();
      b_exp = ~b_exp;
      check8("R2 core_a captured", core_a, va(i));
      check8("R4 pin_b_out alternates", pin_b_out, b_exp);
      prev_core = va(i);
    end
  endtask

  task automatic t_enable_off();
    after_rise();
    oec_b = 1'b0;
    #1;
    check8("R5 drv_en_b off", drv_en_b, 8'h00);
    after_fall();
    b_exp = ~b_exp;
    check8("R4 pin_b_out keeps toggling", pin_b_out, b_exp);
    check8("R2 core_a captured", core_a, pin_a_in);
    a_hold = pin_a_in;
  endtask

  task automatic t_bypass(input logic both);
    after_rise();
    oec_b = 1'b1;
    en_ab = both; en_ba = both;
    pin_a_in = ~a_hold;
    #1;
    check8("R7 drv_en_a bypass", drv_en_a, 8'h00);
    check8("R7 drv_en_b bypass", drv_en_b, 8'h00);
    for (int i = 0; i < 3; i++) after_fall();
    check8("R7 core_a holds", core_a, a_hold);
    check8("R7 pin_b_out holds", pin_b_out, b_exp);
  endtask

  task automatic t_idle();
    after_rise();
    mode_act = 1'b0; en_ab = 1'b1; en_ba = 1'b0;
    pin_a_in = 8'h5A;
    #1;
    check8("R8 drv_en_b idle", drv_en_b, 8'h00);
    for (int i = 0; i < 3; i++) after_fall();
    check8("R8 core_a holds", core_a, a_hold);
    check8("R8 pin_b_out holds", pin_b_out, b_exp);
  endtask

  task automatic t_b_to_a();
    logic [W-1:0] a_exp;
    after_rise();
    mode_act = 1'b1; en_ab = 1'b0; en_ba = 1'b1; oec_a = 1'b1; oec_b = 1'b1;
    pin_b_in = 8'hA1;
    #1;
    check8("R6 drv_en_a driving", drv_en_a, 8'hFF);
    check8("R6 drv_en_b receiving", drv_en_b, 8'h00);
    a_exp = a_hold;
    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] w;
      w = pin_b_in;
      after_rise();
      pin_b_in = w + 8'h13;
      after_fall();
      a_exp = ~a_exp;
      check8("R6 core_b captured", core_b, w);
      check8("R6 pin_a_out alternates", pin_a_out, a_exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; mode_act = 1'b0; en_ab = 1'b0; en_ba = 1'b0;
    oec_a = 1'b0; oec_b = 1'b0; pin_a_in = '0; pin_b_in = '0;
    b_exp = '0; a_hold = '0;
    repeat (3) @(posedge tck);
    #1 rst_n = 1'b1;
    repeat (3) after_rise();
    t_reset();
    t_a_to_b();
    t_enable_off();
    t_bypass(1'b1);
    t_bypass(1'b0);
    t_idle();
    t_b_to_a();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule